// File: doc/BRIEF.md
# Two-Channel Serial Management Register Slave

This block is the management slave of a two-channel transceiver. It watches a serial management clock and data line, decodes Clause 22 style read and write frames, and serves one control word and one status word for each channel. The lowest bit of the 5-bit PHY address picks the channel. The upper four bits must equal a strap input, or the frame is ignored. A frame is accepted only after an unbroken run of at least 32 ones on the data line. Preamble suppression is not offered.

The control word holds three writable bits for each channel: loopback, power down and isolate. These bits drive the channel's control outputs. The loopback output also follows an external pin. Control bit 15 is a global reset. Writing it returns the control bits of both channels to their defaults and raises a reset output for exactly one clock. The status word and the fixed control bits are hard-wired capability values. The bidirectional data line is presented as a separate data output and output enable, so the pad ring can build the tri-state driver.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The data line is sampled on each rising edge of `mdc`. After the preamble, a frame consists of start bits 0,1, an opcode (1,0 = read; 0,1 = write), a 5-bit PHY address, a 5-bit register address, two turnaround bits and 16 data bits. All fields are sent most significant bit first. A written value is returned by a later read of the same register and channel.
- R2: A frame is served only if at least 32 consecutive ones come directly before its start bits. With only 31 ones, a write changes nothing and a read leaves `mdioOe` low.
- R3: PHY address bits 4:1 must equal `phyStrap`, or the frame is ignored. PHY address bit 0 selects channel 0 or channel 1. Each channel keeps its own control bits.
- R4: On a read, `mdioOe` stays low during the first turnaround bit. The data line is driven to 0 during the second turnaround bit. The 16 data bits then follow, MSB first. `mdioOe` falls once the last data bit is done, and it is low at every other time.
- R5: Register 0x00 (control) reads 0x0140 after reset. Bit 14 (loopback), bit 11 (power down) and bit 10 (isolate) are read/write for each channel. Bits 8 and 6 always read 1. All other bits read 0, and writes to them are ignored.
- R6: Register 0x01 (status) always reads 0x0101, and writes to it have no effect.
- R7: A write of control bit 15 to either channel raises `globalResetPulse` for exactly one `mdc` cycle. The control bits of both channels then return to their defaults. Bit 15 reads back as 0, and the other bits of that write are discarded.
- R8: `loopbackOut[c]` is control bit 14 of channel c ORed with `extLoopPin[c]`. The pin does not change the register value that is read back. `powerDownOut[c]` follows bit 11 and `isolateOut[c]` follows bit 10. All outputs are 0 during reset.
- R9: Any register address other than 0x00 and 0x01 reads 0x0000, and writes to it have no effect.
- R10: Reads and writes keep working while a channel's power-down bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mdioIn | input | 1 | Received level of the management data line |
| mdioOut | output | 1 | Level to drive on the data line while enabled |
| mdioOe | output | 1 | Drive enable for the data line |
| phyStrap | input | 4 | Required value of PHY address bits 4:1 |
| extLoopPin | input | 2 | External loopback request for each channel |
| loopbackOut | output | 2 | Loopback control for each channel |
| powerDownOut | output | 2 | Power-down control for each channel |
| isolateOut | output | 2 | Isolate control for each channel |
| globalResetPulse | output | 1 | One-cycle pulse issued by a write of control bit 15 |

## Verification
Several rules are checked by assertions on every clock. The driver must start with a 0 in the turnaround slot, and it may never be on while a write commits. A frame may leave preamble search only after the full run of ones. The reset pulse lasts one cycle and leaves every control bit cleared, and an asserted loopback pin always shows on its output. Other behaviour only the bench scenarios can show. These are the exact read-back values and their bit order, and the separation between channels. They also include discarding frames with a wrong strap or a short preamble, the fixed and unimplemented registers, and the register contents after a global reset.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W   = 16;
  localparam int REG_W    = 5;
  localparam int PHY_W    = 5;
  localparam int CHAN_W   = 1;
  localparam int NUM_CHAN = 1 << CHAN_W;
  localparam int STRAP_W  = PHY_W - CHAN_W;
  localparam int HDR_W    = 2 + PHY_W + REG_W;

  localparam logic [REG_W-1:0] ADDR_CTRL = 5'd0;
  localparam logic [REG_W-1:0] ADDR_STAT = 5'd1;

  localparam logic [DATA_W-1:0] CTRL_FIXED   = 16'h0140;
  localparam logic [DATA_W-1:0] STATUS_VALUE = 16'h0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_TA_RD1, ST_TA_RD2, ST_RDATA, ST_TA_WR, ST_WDATA
  } frameState_t;

  typedef struct packed {
    logic              loadRead;
    logic              shiftData;
    logic              commitWrite;
    logic [CHAN_W-1:0] chan;
    logic [REG_W-1:0]  regAddr;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic               mdc,
  input  logic               rstN,
  input  logic               mdioIn,
  input  logic [STRAP_W-1:0] phyStrap,
  input  logic               readBit,
  output mdioStrobe_t        strobe,
  output logic               mdioOut,
  output logic               mdioOe
);
  localparam int PRM_W = $clog2(PREAMBLE_LEN + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [PRM_W-1:0] PRM_FULL = PRM_W'(PREAMBLE_LEN);
  localparam logic [BIT_W-1:0] HDR_LAST = BIT_W'(HDR_W - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(DATA_W - 1);

  frameState_t       state;
  logic [PRM_W-1:0]  prmCount;
  logic [BIT_W-1:0]  bitCnt;
  logic [HDR_W-2:0]  hdrShift;
  logic [CHAN_W-1:0] chanReg;
  logic [REG_W-1:0]  regAddrReg;

  logic [HDR_W-1:0]  hdrNext;
  logic              opRead, opWrite, phyOk, hdrDone;

  assign hdrNext = {hdrShift, mdioIn};
  assign opRead  = hdrNext[HDR_W-1 -: 2] == 2'b10;
  assign opWrite = hdrNext[HDR_W-1 -: 2] == 2'b01;
  assign phyOk   = hdrNext[REG_W+PHY_W-1 : REG_W+CHAN_W] == phyStrap;
  assign hdrDone = (state == ST_HDR) && (bitCnt == HDR_LAST);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      prmCount   <= '0;
      bitCnt     <= '0;
      hdrShift   <= '0;
      chanReg    <= '0;
      regAddrReg <= '0;
    end else begin
      if (state != ST_IDLE) prmCount <= '0;
      case (state)
        ST_IDLE: begin
          if (mdioIn) begin
            if (prmCount != PRM_FULL) prmCount <= prmCount + 1'b1;
          end else if (prmCount == PRM_FULL) begin
            state <= ST_START;
          end else begin
            prmCount <= '0;
          end
        end
        ST_START: begin
          bitCnt <= '0;
          state  <= mdioIn ? ST_HDR : ST_IDLE;
        end
        ST_HDR: begin
          hdrShift <= hdrNext[HDR_W-2:0];
          bitCnt   <= bitCnt + 1'b1;
          if (hdrDone) begin
            bitCnt     <= '0;
            chanReg    <= hdrNext[REG_W +: CHAN_W];
            regAddrReg <= hdrNext[REG_W-1:0];
            if (phyOk && opRead)       state <= ST_TA_RD1;
            else if (phyOk && opWrite) state <= ST_TA_WR;
            else                       state <= ST_IDLE;
          end
        end
        ST_TA_RD1: state <= ST_TA_RD2;
        ST_TA_RD2: state <= ST_RDATA;
        ST_TA_WR: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt[0]) begin
            bitCnt <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA, ST_WDATA: begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            bitCnt <= '0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadRead    = hdrDone && phyOk && opRead;
    strobe.shiftData   = (state == ST_RDATA) || (state == ST_WDATA);
    strobe.commitWrite = (state == ST_WDATA) && (bitCnt == DATA_LAST);
    strobe.chan        = (state == ST_HDR) ? hdrNext[REG_W +: CHAN_W] : chanReg;
    strobe.regAddr     = (state == ST_HDR) ? hdrNext[REG_W-1:0] : regAddrReg;
  end

  assign mdioOe  = (state == ST_TA_RD2) || (state == ST_RDATA);
  assign mdioOut = (state == ST_RDATA) && readBit;

  // R4: the driver comes on only after the released turnaround bit, starting at 0
  p_ta_release_r4: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> ($past(state) == ST_TA_RD1) && !mdioOut);

  // R1: a write frame never has the slave driving the line
  p_no_drive_write_r1: assert property (@(posedge mdc) disable iff (!rstN)
    strobe.commitWrite |-> !mdioOe);

  // R2: leaving preamble search requires the full run of ones
  p_full_preamble_r2: assert property (@(posedge mdc) disable iff (!rstN)
    (state == ST_START && $past(state) == ST_IDLE) |-> $past(prmCount) == PRM_FULL);
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
(
  input  logic                mdc,
  input  logic                rstN,
  input  logic                mdioIn,
  input  mdioStrobe_t         strobe,
  input  logic [NUM_CHAN-1:0] extLoopPin,
  output logic                readBit,
  output logic [NUM_CHAN-1:0] loopbackOut,
  output logic [NUM_CHAN-1:0] powerDownOut,
  output logic [NUM_CHAN-1:0] isolateOut,
  output logic                globalResetPulse
);
  localparam int BIT_LOOP = 14;
  localparam int BIT_PDN  = 11;
  localparam int BIT_ISO  = 10;
  localparam int BIT_RST  = 15;

  logic [DATA_W-1:0]   dataShift;
  logic [DATA_W-1:0]   writeWord;
  logic [DATA_W-1:0]   readWord;
  logic                softReset;
  logic                ctrlWrite;
  logic [NUM_CHAN-1:0] loopReg, pdnReg, isoReg;

  assign writeWord = {dataShift[DATA_W-2:0], mdioIn};
  assign ctrlWrite = strobe.commitWrite && (strobe.regAddr == ADDR_CTRL);

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      dataShift <= '0;
      softReset <= 1'b0;
    end else begin
      softReset <= ctrlWrite && writeWord[BIT_RST];
      if (strobe.loadRead)       dataShift <= readWord;
      else if (strobe.shiftData) dataShift <= writeWord;
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic loopQ, pdnQ, isoQ;
    always_ff @(posedge mdc or negedge rstN) begin
      if (!rstN) begin
        {loopQ, pdnQ, isoQ} <= 3'b000;
      end else if (softReset) begin
        {loopQ, pdnQ, isoQ} <= 3'b000;
      end else if (ctrlWrite && !writeWord[BIT_RST] && strobe.chan == CHAN_W'(c)) begin
        loopQ <= writeWord[BIT_LOOP];
        pdnQ  <= writeWord[BIT_PDN];
        isoQ  <= writeWord[BIT_ISO];
      end
    end
    assign loopReg[c] = loopQ;
    assign pdnReg[c]  = pdnQ;
    assign isoReg[c]  = isoQ;
  end

  always_comb begin
    readWord = '0;
    case (strobe.regAddr)
      ADDR_CTRL: begin
        readWord           = CTRL_FIXED;
        readWord[BIT_RST]  = softReset;
        readWord[BIT_LOOP] = loopReg[strobe.chan];
        readWord[BIT_PDN]  = pdnReg[strobe.chan];
        readWord[BIT_ISO]  = isoReg[strobe.chan];
      end
      ADDR_STAT: readWord = STATUS_VALUE;
      default:   readWord = '0;
    endcase
  end

  assign readBit          = dataShift[DATA_W-1];
  assign loopbackOut      = loopReg | extLoopPin;
  assign powerDownOut     = pdnReg;
  assign isolateOut       = isoReg;
  assign globalResetPulse = softReset;

  // R7: the reset pulse lasts a single cycle
  p_pulse_single_r7: assert property (@(posedge mdc) disable iff (!rstN)
    globalResetPulse |=> !globalResetPulse);

  // R7: after the pulse every channel's control bits are back at default
  p_reset_clears_r7: assert property (@(posedge mdc) disable iff (!rstN)
    globalResetPulse |=> (powerDownOut == '0) && (isolateOut == '0) && ((loopbackOut & ~extLoopPin) == '0));

  // R8: an asserted external pin always shows on the loopback output
  p_pin_passes_r8: assert property (@(posedge mdc) disable iff (!rstN)
    (loopbackOut & extLoopPin) == extLoopPin);
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic                mdc,
  input  logic                rstN,
  input  logic                mdioIn,
  output logic                mdioOut,
  output logic                mdioOe,
  input  logic [STRAP_W-1:0]  phyStrap,
  input  logic [NUM_CHAN-1:0] extLoopPin,
  output logic [NUM_CHAN-1:0] loopbackOut,
  output logic [NUM_CHAN-1:0] powerDownOut,
  output logic [NUM_CHAN-1:0] isolateOut,
  output logic                globalResetPulse
);
  mdioStrobe_t strobe;
  logic        readBit;

  mdio_frame_ctrl #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_ctrl (
    .mdc      (mdc),
    .rstN     (rstN),
    .mdioIn   (mdioIn),
    .phyStrap (phyStrap),
    .readBit  (readBit),
    .strobe   (strobe),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe)
  );

  mdio_reg_file u_regs (
    .mdc              (mdc),
    .rstN             (rstN),
    .mdioIn           (mdioIn),
    .strobe           (strobe),
    .extLoopPin       (extLoopPin),
    .readBit          (readBit),
    .loopbackOut      (loopbackOut),
    .powerDownOut     (powerDownOut),
    .isolateOut       (isolateOut),
    .globalResetPulse (globalResetPulse)
  );
endmodule

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_slave;
  logic       mdc = 1'b0;
  logic       rstN = 1'b0;
  logic       mdioIn = 1'b0;
  logic       mdioOut, mdioOe;
  logic [3:0] phyStrap = 4'b0101;
  logic [1:0] extLoopPin = 2'b00;
  logic [1:0] loopbackOut, powerDownOut, isolateOut;
  logic       globalResetPulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  string       expTag[$];
  logic [15:0] expVal[$];
  logic [15:0] gotVal[$];

  always #4 mdc = ~mdc;

  mdio_mgmt_slave u0 (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .phyStrap(phyStrap), .extLoopPin(extLoopPin), .loopbackOut(loopbackOut),
    .powerDownOut(powerDownOut), .isolateOut(isolateOut),
    .globalResetPulse(globalResetPulse)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares captured read words against expected queue
  initial begin
    forever begin
      @(negedge mdc);
      while (gotVal.size() > 0 && expVal.size() > 0) begin
        check(expTag.pop_front(), gotVal.pop_front(), expVal.pop_front());
      end
    end
  end

  task automatic sendBit(input logic b);
    @(negedge mdc);
    mdioIn = b;
  endtask

  task automatic sendHeader(input int pre, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] regA);
    for (int i = 0; i < pre; i++) sendBit(1'b1);
    sendBit(1'b0); sendBit(1'b1);
    sendBit(op[1]); sendBit(op[0]);
    for (int i = 4; i >= 0; i--) sendBit(phy[i]);
    for (int i = 4; i >= 0; i--) sendBit(regA[i]);
  endtask

  // ends on the negedge after the commit edge, with the line idle at 0
  task automatic mdioWrite(input int pre, input logic [4:0] phy, input logic [4:0] regA,
                           input logic [15:0] data);
    sendHeader(pre, 2'b01, phy, regA);
    sendBit(1'b1); sendBit(1'b0);
    for (int i = 15; i >= 0; i--) sendBit(data[i]);
    @(negedge mdc);
    mdioIn = 1'b0;
  endtask

  task automatic mdioRead(input int pre, input logic [4:0] phy, input logic [4:0] regA,
                          input logic [15:0] exp, input bit expectDrive, input string tag);
    logic [15:0] got;
    bit anyDrive;
    anyDrive = 0;
    sendHeader(pre, 2'b10, phy, regA);
    @(negedge mdc);
    check({tag, " R4 first turnaround released"}, {15'd0, mdioOe}, 16'd0);
    mdioIn = 1'b1;
    @(negedge mdc);
    anyDrive |= mdioOe;
    if (expectDrive)
      check({tag, " R4 second turnaround drives 0"}, {14'd0, mdioOe, mdioOut}, 16'd2);
    for (int i = 15; i >= 0; i--) begin
      @(negedge mdc);
      anyDrive |= mdioOe;
      got[i] = mdioOe ? mdioOut : 1'b1;
    end
    @(negedge mdc);
    check({tag, " R4 released after data"}, {15'd0, mdioOe}, 16'd0);
    mdioIn = 1'b0;
    if (expectDrive) begin
      expTag.push_back(tag);
      expVal.push_back(exp);
      gotVal.push_back(got);
    end else begin
      check({tag, " R2/R3 ignored read never drives"}, {15'd0, anyDrive}, 16'd0);
    end
  endtask

  task automatic checkPins(input string tag, input logic [1:0] lp, input logic [1:0] pd,
                           input logic [1:0] iso);
    check({tag, " loopbackOut"}, {14'd0, loopbackOut}, {14'd0, lp});
    check({tag, " powerDownOut"}, {14'd0, powerDownOut}, {14'd0, pd});
    check({tag, " isolateOut"}, {14'd0, isolateOut}, {14'd0, iso});
  endtask

  localparam logic [4:0] PHY0 = 5'b01010;
  localparam logic [4:0] PHY1 = 5'b01011;
  localparam logic [4:0] BADPHY = 5'b10100;

  initial begin
    repeat (3) @(negedge mdc);
    checkPins("R8 reset state", 2'b00, 2'b00, 2'b00);
    check("R8 reset state pulse/oe", {14'd0, globalResetPulse, mdioOe}, 16'd0);
    rstN = 1'b1;
    repeat (2) @(negedge mdc);

    // R5 R6 defaults
    mdioRead(32, PHY0, 5'd0, 16'h0140, 1, "R5 ch0 control default");
    mdioRead(32, PHY1, 5'd0, 16'h0140, 1, "R5 ch1 control default");
    mdioRead(32, PHY0, 5'd1, 16'h0101, 1, "R6 status default");

    // R1 R5 round trip on channel 0, fixed bits ignored
    mdioWrite(32, PHY0, 5'd0, 16'h7FFF);
    checkPins("R5 R8 after ch0 write", 2'b01, 2'b01, 2'b01);
    mdioRead(32, PHY0, 5'd0, 16'h4D40, 1, "R1 R5 R10 ch0 round trip");

    // R3 channel 1 independent
    mdioWrite(32, PHY1, 5'd0, 16'h0800);
    checkPins("R3 after ch1 write", 2'b01, 2'b11, 2'b01);
    mdioRead(32, PHY1, 5'd0, 16'h0940, 1, "R3 ch1 round trip");
    mdioRead(32, PHY0, 5'd0, 16'h4D40, 1, "R3 ch0 untouched by ch1");

    // R6 status write ignored, R9 unimplemented register
    mdioWrite(32, PHY0, 5'd1, 16'hFFFF);
    mdioRead(32, PHY0, 5'd1, 16'h0101, 1, "R6 status after write");
    mdioWrite(32, PHY0, 5'd5, 16'hFFFF);
    mdioRead(32, PHY0, 5'd5, 16'h0000, 1, "R9 unimplemented reads zero");
    mdioRead(32, PHY0, 5'd0, 16'h4D40, 1, "R9 control unchanged");

    // R3 wrong strap ignored
    mdioWrite(32, BADPHY, 5'd0, 16'h0000);
    mdioRead(32, PHY0, 5'd0, 16'h4D40, 1, "R3 wrong strap write ignored");
    mdioRead(32, BADPHY, 5'd0, 16'h0000, 0, "R3 wrong strap read");

    // R2 short preamble
    mdioWrite(31, PHY0, 5'd0, 16'h0000);
    checkPins("R2 short preamble write", 2'b01, 2'b11, 2'b01);
    mdioRead(32, PHY0, 5'd0, 16'h4D40, 1, "R2 short preamble write ignored");
    mdioRead(31, PHY0, 5'd0, 16'h0000, 0, "R2 short preamble read");

    // R8 external loopback pin
    extLoopPin = 2'b10;
    @(negedge mdc);
    checkPins("R8 pin on ch1", 2'b11, 2'b11, 2'b01);
    mdioRead(32, PHY1, 5'd0, 16'h0940, 1, "R8 pin not in register");
    extLoopPin = 2'b00;
    @(negedge mdc);
    checkPins("R8 pin off", 2'b01, 2'b11, 2'b01);

    // R7 global self-clearing reset
    mdioWrite(32, PHY0, 5'd0, 16'hFFFF);
    check("R7 pulse high", {15'd0, globalResetPulse}, 16'd1);
    @(negedge mdc);
    check("R7 pulse self-clears", {15'd0, globalResetPulse}, 16'd0);
    checkPins("R7 both channels cleared", 2'b00, 2'b00, 2'b00);
    mdioRead(32, PHY0, 5'd0, 16'h0140, 1, "R7 ch0 default after reset");
    mdioRead(32, PHY1, 5'd0, 16'h0140, 1, "R7 ch1 default after reset");

    repeat (4) @(negedge mdc);
    if (expVal.size() != 0) check("scoreboard drained", 16'(expVal.size()), 16'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge mdc);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule